// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block times the readout of an active pixel array that uses an electronic rolling shutter. A frame begins when `frame_start_i` is seen while the block is idle. Each row then gets the same fixed pulse sequence, and the strobes are shared by every column of that row:

1. The row is selected and its floating diffusion is reset.
2. The reset level is sampled.
3. The photo-charge is transferred onto the floating diffusion.
4. The signal level is sampled.

The two samples form a correlated pair. Only once the row has been sampled does a column counter step across the stored column samples, one per clock, for serial readout. Reading a row also resets it.

A second pointer, the shutter pointer, runs a fixed number of rows ahead of the read pointer. It resets its row while the read row is in its reset phase, so that row starts integrating. A row's integration time is therefore the pointer gap multiplied by the row period. The row period is four phase lengths plus the column count.

The row count, column count, exposure gap and phase length are all captured when a frame is accepted. Later changes to those inputs cannot tear a running frame. The analog pixel and conversion circuits sit outside this block.

Top module: `rs_row_sequencer`

## Requirements
- R1: After reset and while idle, every strobe, `line_valid_o` and `frame_valid_o` are low, and `rd_row_o`, `shut_row_o` and `col_o` are zero. Without `frame_start_i` the block stays idle.
- R2: For each row, four phases follow in this order: floating-diffusion reset (`fd_rst_o`), reset-level sample (`shr_o`), transfer (`tx_o`), signal-level sample (`shs_o`). Each phase lasts L = max(`phase_len_i`,1) clocks. `row_sel_o` is high throughout all four phases, and exactly one of the four phase strobes is high in each of those cycles.
- R3: Straight after the signal sample, `line_valid_o` is high for C = max(`num_cols_i`,1) clocks. During that time `col_o` counts 0 to C-1, one step per clock, and `row_sel_o` and all phase strobes are low.
- R4: Rows are read in the order 0 to R-1, where R = max(`num_rows_i`,1), and the block then returns to idle. `frame_valid_o` is high from the first reset cycle of row 0 through the last scan cycle of row R-1.
- R5: During a frame, `shut_row_o` = (`rd_row_o` + E) mod R, where E is the latched exposure gap. `shut_rst_o` is high exactly during the floating-diffusion reset phase of each row.
- R6: E = 1 when `exposure_i` is 0, E = R when `exposure_i` is greater than R, and E = `exposure_i` otherwise.
- R7: The row count, column count, exposure and phase length are sampled only in the cycle that accepts `frame_start_i`. Changes to those inputs during a frame have no effect, and `frame_start_i` held high during a frame is ignored.
- R8: The first `fd_rst_o` cycle is the cycle straight after the clock edge at which an idle block samples `frame_start_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Request to begin a frame; honoured only when idle |
| num_rows_i | input | ROW_W | Rows per frame (0 is treated as 1) |
| num_cols_i | input | COL_W | Columns per row (0 is treated as 1) |
| exposure_i | input | ROW_W | Gap between shutter pointer and read pointer, in rows |
| phase_len_i | input | CNT_W | Clocks per pulse phase (0 is treated as 1) |
| row_sel_o | output | 1 | Row select for the read row |
| fd_rst_o | output | 1 | Floating-diffusion reset of the read row |
| shr_o | output | 1 | Reset-level sample strobe |
| tx_o | output | 1 | Charge transfer pulse |
| shs_o | output | 1 | Signal-level sample strobe |
| shut_rst_o | output | 1 | Reset of the shutter-pointer row |
| rd_row_o | output | ROW_W | Read row address |
| shut_row_o | output | ROW_W | Shutter row address |
| col_o | output | COL_W | Column address during scan |
| line_valid_o | output | 1 | Column scan active |
| frame_valid_o | output | 1 | Frame in progress |

## Verification
On every cycle, the embedded assertions check the following:
- The phase strobes and the scan window never overlap.
- Each strobe rises only straight after its predecessor in the sample order.
- The shutter row and column address stay inside the latched counts.
- The latched exposure does not move during a frame.

Only the bench's sweep can show the rest: the exact phase lengths, the row order, the modulo relation between the two pointers, the clamping of the exposure value, and the fact that inputs changed mid-frame leave the frame untouched. To do this it compares every output on every cycle against an arithmetic model over many row, column, phase-length and exposure combinations.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RST  = 3'd1,
        PH_SHR  = 3'd2,
        PH_TX   = 3'd3,
        PH_SHS  = 3'd4,
        PH_SCAN = 3'd5
    } phase_e;

    typedef struct packed {
        logic row_sel;
        logic fd_rst;
        logic shr;
        logic tx;
        logic shs;
        logic shut_rst;
        logic line_valid;
        logic frame_valid;
    } strobe_t;

    function automatic strobe_t decode_phase(phase_e ph);
        strobe_t s;
        s = '0;
        case (ph)
            PH_RST: begin
                s.row_sel  = 1'b1;
                s.fd_rst   = 1'b1;
                s.shut_rst = 1'b1;
            end
            PH_SHR: begin
                s.row_sel = 1'b1;
                s.shr     = 1'b1;
            end
            PH_TX: begin
                s.row_sel = 1'b1;
                s.tx      = 1'b1;
            end
            PH_SHS: begin
                s.row_sel = 1'b1;
                s.shs     = 1'b1;
            end
            PH_SCAN: s.line_valid = 1'b1;
            default: s = '0;
        endcase
        s.frame_valid = (ph != PH_IDLE);
        return s;
    endfunction

endpackage

// File: rtl/rs_phase_timer.sv
module rs_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

    assign done_o = (cnt_q == last_i);

    // R2
    timer_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_i);

endmodule

// File: rtl/rs_col_scan.sv
module rs_col_scan #(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [COL_W-1:0] last_i,
    output logic [COL_W-1:0] col_o,
    output logic             wrap_o
);
    logic [COL_W-1:0] col_q;

    assign wrap_o = en_i && (col_q == last_i);

    always_ff @(posedge clk) begin
        if (rst)         col_q <= '0;
        else if (wrap_o) col_q <= '0;
        else if (en_i)   col_q <= col_q + COL_W'(1);
    end

    assign col_o = col_q;

    // R3
    col_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (col_q <= last_i));

    // R3
    col_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (col_q == '0));

endmodule

// File: rtl/rs_row_ptr.sv
module rs_row_ptr #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [ROW_W-1:0] last_i,
    input  logic [ROW_W-1:0] shut_init_i,
    output logic [ROW_W-1:0] rd_o,
    output logic [ROW_W-1:0] shut_o,
    output logic             at_last_o
);
    logic [ROW_W-1:0] rd_q;
    logic [ROW_W-1:0] shut_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            shut_q <= '0;
        end else if (start_i) begin
            rd_q   <= '0;
            shut_q <= shut_init_i;
        end else if (step_i) begin
            rd_q   <= rd_q + ROW_W'(1);
            shut_q <= (shut_q == last_i) ? '0 : shut_q + ROW_W'(1);
        end
    end

    assign rd_o      = rd_q;
    assign shut_o    = shut_q;
    assign at_last_o = (rd_q == last_i);

    // R4
    no_step_past_last_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (rd_q < last_i));

endmodule

// File: rtl/rs_row_sequencer.sv
module rs_row_sequencer
    import rs_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic [ROW_W-1:0] num_rows_i,
    input  logic [COL_W-1:0] num_cols_i,
    input  logic [ROW_W-1:0] exposure_i,
    input  logic [CNT_W-1:0] phase_len_i,
    output logic             row_sel_o,
    output logic             fd_rst_o,
    output logic             shr_o,
    output logic             tx_o,
    output logic             shs_o,
    output logic             shut_rst_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [ROW_W-1:0] shut_row_o,
    output logic [COL_W-1:0] col_o,
    output logic             line_valid_o,
    output logic             frame_valid_o
);
    phase_e           phase_q, phase_d;
    strobe_t          stb;
    logic             accept;
    logic             tmr_done, tmr_clr;
    logic             col_wrap, row_last, row_step;
    logic [ROW_W-1:0] rows_eff, exp_eff, shut_init;
    logic [ROW_W-1:0] rows_last_q, exp_q;
    logic [COL_W-1:0] cols_last_q;
    logic [CNT_W-1:0] plen_last_q;
    logic [ROW_W-1:0] rd_ptr, shut_ptr;

    assign accept = (phase_q == PH_IDLE) && frame_start_i;

    // configuration captured at frame acceptance
    always_comb begin
        rows_eff = (num_rows_i == '0) ? ROW_W'(1) : num_rows_i;
        if (exposure_i == '0)          exp_eff = ROW_W'(1);
        else if (exposure_i > rows_eff) exp_eff = rows_eff;
        else                           exp_eff = exposure_i;
        shut_init = (exp_eff == rows_eff) ? '0 : exp_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_last_q <= '0;
            cols_last_q <= '0;
            plen_last_q <= '0;
            exp_q       <= ROW_W'(1);
        end else if (accept) begin
            rows_last_q <= rows_eff - ROW_W'(1);
            cols_last_q <= (num_cols_i == '0) ? '0 : num_cols_i - COL_W'(1);
            plen_last_q <= (phase_len_i == '0) ? '0 : phase_len_i - CNT_W'(1);
            exp_q       <= exp_eff;
        end
    end

    // phase sequencing
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (accept)   phase_d = PH_RST;
            PH_RST:  if (tmr_done) phase_d = PH_SHR;
            PH_SHR:  if (tmr_done) phase_d = PH_TX;
            PH_TX:   if (tmr_done) phase_d = PH_SHS;
            PH_SHS:  if (tmr_done) phase_d = PH_SCAN;
            PH_SCAN: if (col_wrap) phase_d = row_last ? PH_IDLE : PH_RST;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign tmr_clr  = (phase_q == PH_IDLE) || (phase_q == PH_SCAN) || tmr_done;
    assign row_step = col_wrap && !row_last;

    rs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (tmr_clr),
        .last_i (plen_last_q),
        .done_o (tmr_done)
    );

    rs_col_scan #(.COL_W(COL_W)) u_cols (
        .clk    (clk),
        .rst    (rst),
        .en_i   (phase_q == PH_SCAN),
        .last_i (cols_last_q),
        .col_o  (col_o),
        .wrap_o (col_wrap)
    );

    rs_row_ptr #(.ROW_W(ROW_W)) u_rows (
        .clk         (clk),
        .rst         (rst),
        .start_i     (accept),
        .step_i      (row_step),
        .last_i      (rows_last_q),
        .shut_init_i (shut_init),
        .rd_o        (rd_ptr),
        .shut_o      (shut_ptr),
        .at_last_o   (row_last)
    );

    assign stb           = decode_phase(phase_q);
    assign row_sel_o     = stb.row_sel;
    assign fd_rst_o      = stb.fd_rst;
    assign shr_o         = stb.shr;
    assign tx_o          = stb.tx;
    assign shs_o         = stb.shs;
    assign shut_rst_o    = stb.shut_rst;
    assign line_valid_o  = stb.line_valid;
    assign frame_valid_o = stb.frame_valid;
    assign rd_row_o      = stb.frame_valid ? rd_ptr   : '0;
    assign shut_row_o    = stb.frame_valid ? shut_ptr : '0;

    // R2
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fd_rst_o, shr_o, tx_o, shs_o, line_valid_o}));

    // R2
    shr_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shr_o) |-> $past(fd_rst_o));

    // R2
    tx_after_shr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_o) |-> $past(shr_o));

    // R2
    shs_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shs_o) |-> $past(tx_o));

    // R3
    scan_after_shs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_valid_o) |-> $past(shs_o));

    // R3
    scan_row_idle_chk: assert property (@(posedge clk) disable iff (rst)
        line_valid_o |-> !row_sel_o);

    // R5
    shut_row_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |-> (shut_row_o <= rows_last_q));

    // R7
    exposure_held_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_valid_o && $past(frame_valid_o)) |-> $stable(exp_q));

endmodule

// File: tb/rs_row_sequencer_test.sv
module rs_row_sequencer_test;
    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_start_i;
    logic [ROW_W-1:0] num_rows_i;
    logic [COL_W-1:0] num_cols_i;
    logic [ROW_W-1:0] exposure_i;
    logic [CNT_W-1:0] phase_len_i;
    logic             row_sel_o, fd_rst_o, shr_o, tx_o, shs_o, shut_rst_o;
    logic [ROW_W-1:0] rd_row_o, shut_row_o;
    logic [COL_W-1:0] col_o;
    logic             line_valid_o, frame_valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rs_row_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i),
        .num_rows_i(num_rows_i), .num_cols_i(num_cols_i),
        .exposure_i(exposure_i), .phase_len_i(phase_len_i),
        .row_sel_o(row_sel_o), .fd_rst_o(fd_rst_o), .shr_o(shr_o),
        .tx_o(tx_o), .shs_o(shs_o), .shut_rst_o(shut_rst_o),
        .rd_row_o(rd_row_o), .shut_row_o(shut_row_o), .col_o(col_o),
        .line_valid_o(line_valid_o), .frame_valid_o(frame_valid_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // strobe vector {row_sel, fd_rst, shr, tx, shs, shut_rst}
    function automatic int strobes();
        return int'({row_sel_o, fd_rst_o, shr_o, tx_o, shs_o, shut_rst_o});
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " strobes"}, strobes(), 0);
        chk({tag, " valids"}, int'({line_valid_o, frame_valid_o}), 0);
        chk({tag, " addresses"}, int'({rd_row_o, shut_row_o, col_o}), 0);
    endtask

    task automatic run_frame(input int r_in, input int c_in, input int l_in,
                             input int e_in, input bit hold);
        int R, C, L, E, T, F;
        string stag;
        R = (r_in == 0) ? 1 : r_in;
        C = (c_in == 0) ? 1 : c_in;
        L = (l_in == 0) ? 1 : l_in;
        E = (e_in == 0) ? 1 : ((e_in > R) ? R : e_in);
        stag = (e_in == 0 || e_in > R) ? "R6 clamped shutter row" : "R5 shutter row";
        T = 4 * L + C;
        F = R * T;
        num_rows_i    = ROW_W'(r_in);
        num_cols_i    = COL_W'(c_in);
        phase_len_i   = CNT_W'(l_in);
        exposure_i    = ROW_W'(e_in);
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = hold;
        // R7: disturb the configuration inputs after acceptance
        num_rows_i  = num_rows_i ^ 4'hA;
        num_cols_i  = num_cols_i ^ 4'h5;
        phase_len_i = phase_len_i ^ 3'h6;
        exposure_i  = exposure_i ^ 4'h3;
        for (int k = 0; k <= F; k++) begin
            if (k < F) begin
                int p, o, es, ec;
                p = k / T;
                o = k % T;
                if (o < L)          es = 6'b110001;
                else if (o < 2 * L) es = 6'b101000;
                else if (o < 3 * L) es = 6'b100100;
                else if (o < 4 * L) es = 6'b100010;
                else                es = 0;
                ec = (o >= 4 * L) ? o - 4 * L : 0;
                if (k == 0) chk("R8 first reset cycle", int'(fd_rst_o), 1);
                chk("R2 phase strobes", strobes(), es);
                chk("R3 column scan", int'({line_valid_o, col_o}),
                    ((o >= 4 * L) ? 16 : 0) + ec);
                chk("R4 read row and frame valid", int'({frame_valid_o, rd_row_o}), 16 + p);
                chk(stag, int'(shut_row_o), (p + E) % R);
            end else begin
                check_idle(hold ? "R7 held start ignored, R4 end of frame" : "R4 end of frame");
            end
            if (k >= F - 1) frame_start_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        rst           = 1'b1;
        frame_start_i = 1'b0;
        num_rows_i    = '0;
        num_cols_i    = '0;
        exposure_i    = '0;
        phase_len_i   = '0;
        repeat (4) @(negedge clk);
        check_idle("R1 in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 idle without start");
        begin
            int rows_set[3] = '{1, 3, 5};
            int cols_set[2] = '{1, 4};
            int len_set[2]  = '{0, 3};
            foreach (rows_set[i])
                foreach (cols_set[j])
                    foreach (len_set[m])
                        for (int e = 0; e < 4; e++) begin
                            int ev;
                            case (e)
                                0: ev = 0;
                                1: ev = 2;
                                2: ev = rows_set[i];
                                default: ev = rows_set[i] + 3;
                            endcase
                            run_frame(rows_set[i], cols_set[j], len_set[m], ev, e[0]);
                        end
        end
        // R4: zero row/column counts act as one each
        run_frame(0, 0, 1, 1, 1'b0);
        repeat (2) @(negedge clk);
        check_idle("R1 idle after sweep");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule